// File: doc/BRIEF.md
# DMA Job Sequencer

This block decides which job of a descriptor-driven DMA controller owns the transfer engine at any moment. It holds a small control word per job: enable, cancel request, interrupt enable and hardware trigger. It picks the next job to run and hands that job to the engine through a start pulse, a per-step grant and a done return. A job whose enable bit is cleared while it runs is parked on a last-in first-out stack of suspended jobs, so its unfinished work can be resumed later. A single cancel request throws away the running job and every parked job at once, and pulses an abort toward the engine.

Software-triggered and hardware-triggered jobs go through the same path. A hardware-triggered job becomes eligible only while its external start line is high, and the engine receives a grant for each step of that job only while its request line is high. When a job finishes, its enable bit clears itself. If the job allows interrupts, its bit in the interrupt-state vector is set, and the interrupt output goes high while any bit of that vector is set. The busy flag, the running job number and the stack depth are visible at the ports.

Top module: `dma_job_sequencer`

## Requirements
- R1: After reset, busy, stack depth, interrupt state, the interrupt output, start, grant and abort are all 0.
- R2: A control write uses bit 0 as enable, bit 1 as cancel, bit 2 as interrupt enable and bit 3 as hardware trigger, and takes effect on the next cycle. When the sequencer is idle, the lowest-numbered eligible job starts first. A job is eligible when it is enabled, not suspended, and either not hardware-triggered or has its start line high. In the first cycle of a run, eng_start is 1 and eng_job carries the job number.
- R3: If a running job's enable bit reads 0 and no done arrives in that cycle, the job is pushed onto the suspend stack, busy drops on the next cycle, the depth grows by one and no finish is recorded.
- R4: A suspended job resumes only when no eligible job exists and it is on top of the stack with its enable bit set again. Resumption is in last-in first-out order.
- R5: A write with the cancel bit set makes eng_abort 1 for exactly the following cycle. After that cycle the sequencer is idle, the stack is empty, and the enable bits of the cancelled running and suspended jobs are cleared, for hardware jobs as well.
- R6: A hardware-triggered job never starts while its start line is low. While it runs, eng_grant is 1 only in cycles where its request line is 1.
- R7: When done arrives for the running job, the job's enable bit clears. Its interrupt-state bit is set only if its interrupt enable is 1, and irq_o is 1 exactly while any interrupt-state bit is set.
- R8: Writing irq_clr_mask with irq_clr_we clears exactly the masked interrupt-state bits and leaves the others set.
- R9: The stack holds every job at once (N_JOBS entries), and stack_depth reports the count up to N_JOBS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_job | input | JW | Job addressed by the write |
| cfg_wdata | input | 4 | Control word: hw, irq_en, cancel, enable (bit 3..0) |
| irq_clr_we | input | 1 | Interrupt-state clear strobe |
| irq_clr_mask | input | N_JOBS | Bits to clear (write one to clear) |
| hw_start | input | N_JOBS | Per-job hardware start lines |
| hw_req | input | N_JOBS | Per-job hardware step request lines |
| eng_done | input | 1 | Engine reports the running job finished |
| eng_start | output | 1 | First cycle of a job run |
| eng_job | output | JW | Job owning the engine |
| eng_grant | output | 1 | Engine may perform a step this cycle |
| eng_abort | output | 1 | Engine must drop the current job |
| busy | output | 1 | A job is running |
| run_job | output | JW | Running job number |
| stack_depth | output | DW | Number of suspended jobs |
| irq_state | output | N_JOBS | Per-job finish flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A stale suspend mask or a misplaced stack pointer appears as a wrong job number on eng_job the next time the sequencer goes idle. It can also appear as a job that restarts fresh when it should resume, which shows up within one cycle of the decision. A lost cancel or a cleared enable that survives shows up as busy rising again after the abort cycle. A wrong interrupt mask shows up in irq_state on the cycle after done. Because the bench compares every output against a behavioural model on every clock, any such divergence is reported in the cycle where it first reaches the ports.

// File: rtl/dma_jobseq_pkg.sv
package dma_jobseq_pkg;

   // Control word layout, bit 3 down to bit 0
   typedef struct packed {
      logic hw;
      logic irq_en;
      logic cancel;
      logic en;
   } job_ctl_t;

   localparam int CTL_W = $bits(job_ctl_t);

endpackage

// File: rtl/jobseq_ctl_regs.sv
module jobseq_ctl_regs
   import dma_jobseq_pkg::*;
#(
   parameter int N_JOBS = 32,
   localparam int JW = $clog2(N_JOBS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [JW-1:0]     wr_job,
   input  job_ctl_t          wr_ctl,
   input  logic [N_JOBS-1:0] clr_en,
   output logic [N_JOBS-1:0] en_o,
   output logic [N_JOBS-1:0] ie_o,
   output logic [N_JOBS-1:0] hw_o
);

   for (genvar j = 0; j < N_JOBS; j++) begin : g_job
      logic hit;
      assign hit = wr_en && (wr_job == JW'(j));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_o[j] <= 1'b0;
            ie_o[j] <= 1'b0;
            hw_o[j] <= 1'b0;
         end else if (hit) begin
            en_o[j] <= wr_ctl.en;
            ie_o[j] <= wr_ctl.irq_en;
            hw_o[j] <= wr_ctl.hw;
         end else if (clr_en[j]) begin
            en_o[j] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/jobseq_pick.sv
module jobseq_pick #(
   parameter int N_JOBS = 32,
   localparam int JW = $clog2(N_JOBS)
) (
   input  logic [N_JOBS-1:0] req,
   output logic              valid,
   output logic [JW-1:0]     idx
);

   always_comb begin
      idx = '0;
      for (int j = N_JOBS - 1; j >= 0; j--) begin
         if (req[j]) idx = JW'(j);
      end
   end

   assign valid = |req;

endmodule

// File: rtl/jobseq_lifo.sv
module jobseq_lifo #(
   parameter int N_JOBS = 32,
   localparam int JW = $clog2(N_JOBS),
   localparam int DW = $clog2(N_JOBS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [JW-1:0] push_idx,
   input  logic          pop,
   input  logic          flush,
   output logic [JW-1:0] top_idx,
   output logic [DW-1:0] depth
);

   logic [JW-1:0] slot [N_JOBS];
   logic [DW-1:0] sp_m1;

   assign sp_m1   = depth - 1'b1;
   assign top_idx = slot[sp_m1[JW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !flush) slot[depth[JW-1:0]] <= push_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         depth <= '0;
      else if (flush)                     depth <= '0;
      else if (push)                      depth <= depth + 1'b1;
      else if (pop && depth != '0)        depth <= sp_m1;
   end

endmodule

// File: rtl/dma_job_sequencer.sv
module dma_job_sequencer
   import dma_jobseq_pkg::*;
#(
   parameter int N_JOBS = 32,
   localparam int JW = $clog2(N_JOBS),
   localparam int DW = $clog2(N_JOBS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [JW-1:0]     cfg_job,
   input  logic [CTL_W-1:0]  cfg_wdata,
   input  logic              irq_clr_we,
   input  logic [N_JOBS-1:0] irq_clr_mask,
   input  logic [N_JOBS-1:0] hw_start,
   input  logic [N_JOBS-1:0] hw_req,
   input  logic              eng_done,
   output logic              eng_start,
   output logic [JW-1:0]     eng_job,
   output logic              eng_grant,
   output logic              eng_abort,
   output logic              busy,
   output logic [JW-1:0]     run_job,
   output logic [DW-1:0]     stack_depth,
   output logic [N_JOBS-1:0] irq_state,
   output logic              irq_o
);

   initial begin
      if (N_JOBS < 2) $error("N_JOBS must be at least 2");
      if (N_JOBS != (1 << JW)) $error("N_JOBS must be a power of two");
   end

   localparam logic [N_JOBS-1:0] ONE  = {{(N_JOBS-1){1'b0}}, 1'b1};
   localparam logic [N_JOBS-1:0] NONE = {N_JOBS{1'b0}};

   job_ctl_t          wctl;
   logic [N_JOBS-1:0] en_v, ie_v, hw_v, clr_en, elig, susp_q, run_1h, top_1h, irq_set;
   logic              busy_q, start_q, cancel_q;
   logic [JW-1:0]     run_job_q, pick_idx, top_idx;
   logic              pick_valid;
   logic              done_evt, susp_evt, idle_ok, start_new, resume;

   assign wctl = job_ctl_t'(cfg_wdata);

   jobseq_ctl_regs #(.N_JOBS(N_JOBS)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_job(cfg_job), .wr_ctl(wctl),
      .clr_en(clr_en), .en_o(en_v), .ie_o(ie_v), .hw_o(hw_v)
   );

   assign elig = en_v & ~susp_q & (~hw_v | hw_start);

   jobseq_pick #(.N_JOBS(N_JOBS)) pick_i (
      .req(elig), .valid(pick_valid), .idx(pick_idx)
   );

   assign run_1h = ONE << run_job_q;
   assign top_1h = ONE << top_idx;

   assign done_evt  = busy_q && !cancel_q && eng_done;
   assign susp_evt  = busy_q && !cancel_q && !eng_done && !en_v[run_job_q];
   assign idle_ok   = !busy_q && !cancel_q;
   assign start_new = idle_ok && pick_valid;
   assign resume    = idle_ok && !pick_valid && (stack_depth != '0) && en_v[top_idx];

   jobseq_lifo #(.N_JOBS(N_JOBS)) lifo_i (
      .clk(clk), .rst_n(rst_n), .push(susp_evt), .push_idx(run_job_q),
      .pop(resume), .flush(cancel_q), .top_idx(top_idx), .depth(stack_depth)
   );

   assign clr_en  = (done_evt ? run_1h : NONE)
                  | (cancel_q ? (susp_q | (busy_q ? run_1h : NONE)) : NONE);
   assign irq_set = (done_evt && ie_v[run_job_q]) ? run_1h : NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         start_q   <= 1'b0;
         cancel_q  <= 1'b0;
         run_job_q <= '0;
         susp_q    <= NONE;
         irq_state <= NONE;
      end else begin
         cancel_q <= cfg_we && wctl.cancel;
         start_q  <= start_new || resume;
         if (cancel_q || done_evt || susp_evt) busy_q <= 1'b0;
         else if (start_new || resume)        busy_q <= 1'b1;
         if (start_new)   run_job_q <= pick_idx;
         else if (resume) run_job_q <= top_idx;
         if (cancel_q) susp_q <= NONE;
         else          susp_q <= (susp_q | (susp_evt ? run_1h : NONE)) & ~(resume ? top_1h : NONE);
         irq_state <= (irq_state & ~(irq_clr_we ? irq_clr_mask : NONE)) | irq_set;
      end
   end

   assign eng_start = start_q;
   assign eng_job   = run_job_q;
   assign eng_abort = cancel_q;
   assign eng_grant = busy_q && !cancel_q && en_v[run_job_q] && (!hw_v[run_job_q] || hw_req[run_job_q]);
   assign busy      = busy_q;
   assign run_job   = run_job_q;
   assign irq_o     = |irq_state;

endmodule

// File: rtl/jobseq_chk.sv
module jobseq_chk #(
   parameter int N_JOBS = 32,
   localparam int JW = $clog2(N_JOBS),
   localparam int DW = $clog2(N_JOBS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic [JW-1:0]     run_job,
   input logic [DW-1:0]     stack_depth,
   input logic              eng_start,
   input logic              eng_grant,
   input logic              eng_abort,
   input logic              eng_done,
   input logic [N_JOBS-1:0] hw_req,
   input logic [N_JOBS-1:0] en_v,
   input logic [N_JOBS-1:0] ie_v,
   input logic [N_JOBS-1:0] hw_v,
   input logic [N_JOBS-1:0] irq_state
);

   // R5
   abort_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |=> (!busy && stack_depth == '0));

   // R3
   suspend_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_abort && !eng_done && !en_v[run_job])
      |=> (!busy && 32'(stack_depth) == 32'($past(stack_depth)) + 1));

   // R9
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(stack_depth) <= N_JOBS);

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> busy);

   // R6
   hw_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_grant && hw_v[run_job]) |-> hw_req[run_job]);

   // R7
   finish_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_abort && eng_done && ie_v[run_job]) |=> irq_state[$past(run_job)]);

endmodule

bind dma_job_sequencer jobseq_chk #(.N_JOBS(N_JOBS)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .run_job(run_job), .stack_depth(stack_depth),
   .eng_start(eng_start), .eng_grant(eng_grant), .eng_abort(eng_abort), .eng_done(eng_done),
   .hw_req(hw_req), .en_v(en_v), .ie_v(ie_v), .hw_v(hw_v), .irq_state(irq_state)
);

// File: tb/dma_job_sequencer_tb_top.sv
module dma_job_sequencer_tb_top;
   localparam int N = 32;
   localparam int JW = 5;
   localparam int DW = 6;
   localparam int LAT = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          cfg_we = 0, irq_clr_we = 0, eng_done = 0;
   logic [JW-1:0] cfg_job = '0;
   logic [3:0]    cfg_wdata = '0;
   logic [N-1:0]  irq_clr_mask = '0, hw_start = '0, hw_req = '0;
   logic          eng_start, eng_grant, eng_abort, busy, irq_o;
   logic [JW-1:0] eng_job, run_job;
   logic [DW-1:0] stack_depth;
   logic [N-1:0]  irq_state;

   dma_job_sequencer #(.N_JOBS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_job(cfg_job), .cfg_wdata(cfg_wdata),
      .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask), .hw_start(hw_start),
      .hw_req(hw_req), .eng_done(eng_done), .eng_start(eng_start), .eng_job(eng_job),
      .eng_grant(eng_grant), .eng_abort(eng_abort), .busy(busy), .run_job(run_job),
      .stack_depth(stack_depth), .irq_state(irq_state), .irq_o(irq_o)
   );

   int checks = 0, errors = 0;
   bit m_en[N], m_ie[N], m_hw[N];
   int m_stack[$];
   int starts[$];
   bit m_busy = 0, m_start = 0, m_cancel = 0;
   int m_run = 0;
   logic [N-1:0] m_irq = '0;
   int rem[N];

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit in_stack(int j);
      foreach (m_stack[i]) if (m_stack[i] == j) return 1;
      return 0;
   endfunction

   task automatic model_step();
      bit n_en[N];
      bit m_grant_unused;
      logic [N-1:0] set_v;
      int pick;
      n_en = m_en;
      set_v = '0;
      m_grant_unused = 0;
      if (m_cancel) begin
         if (m_busy) n_en[m_run] = 0;
         foreach (m_stack[i]) n_en[m_stack[i]] = 0;
         m_stack.delete();
         m_busy = 0; m_start = 0;
      end else if (m_busy) begin
         m_start = 0;
         if (eng_done) begin
            n_en[m_run] = 0;
            if (m_ie[m_run]) set_v[m_run] = 1'b1;
            m_busy = 0;
         end else if (!m_en[m_run]) begin
            m_stack.push_back(m_run);
            m_busy = 0;
         end
      end else begin
         pick = -1;
         for (int j = N - 1; j >= 0; j--)
            if (m_en[j] && !in_stack(j) && (!m_hw[j] || hw_start[j])) pick = j;
         if (pick >= 0) begin
            m_run = pick; m_busy = 1; m_start = 1;
         end else if (m_stack.size() > 0 && m_en[m_stack[$]]) begin
            m_run = m_stack.pop_back(); m_busy = 1; m_start = 1;
         end else m_start = 0;
      end
      m_irq = (m_irq & ~(irq_clr_we ? irq_clr_mask : '0)) | set_v;
      m_en = n_en;
      if (cfg_we) begin
         m_en[cfg_job] = cfg_wdata[0];
         m_ie[cfg_job] = cfg_wdata[2];
         m_hw[cfg_job] = cfg_wdata[3];
      end
      m_cancel = cfg_we && cfg_wdata[1];
   endtask

   task automatic cycle();
      bit g;
      #1;
      if (eng_abort) foreach (rem[i]) rem[i] = 0;
      if (eng_start && rem[eng_job] == 0) rem[eng_job] = LAT;
      eng_done = 0;
      if (eng_grant && rem[eng_job] > 0) begin
         rem[eng_job]--;
         if (rem[eng_job] == 0) eng_done = 1;
      end
      #1;
      if (eng_start) starts.push_back(int'(eng_job));
      g = m_busy && !m_cancel && m_en[m_run] && (!m_hw[m_run] || hw_req[m_run]);
      chk("R2 busy", busy, m_busy);
      if (m_busy) chk("R2 run_job", run_job, m_run);
      chk("R2 start", eng_start, m_start);
      chk("R9 depth", stack_depth, m_stack.size());
      chk("R7 irq_state", irq_state, m_irq);
      chk("R7 irq_o", irq_o, m_irq != '0);
      chk("R6 grant", eng_grant, g);
      chk("R5 abort", eng_abort, m_cancel);
      model_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) cycle();
   endtask

   task automatic wr(int job, bit en, bit cancel, bit ie, bit hw);
      cfg_we = 1; cfg_job = JW'(job); cfg_wdata = {hw, ie, cancel, en};
      cycle();
      cfg_we = 0;
   endtask

   task automatic clr_irq(logic [N-1:0] m);
      irq_clr_we = 1; irq_clr_mask = m;
      cycle();
      irq_clr_we = 0; irq_clr_mask = '0;
   endtask

   function automatic logic [63:0] seq_code();
      logic [63:0] c = '0;
      foreach (starts[i]) c = (c << 6) | 64'(starts[i] + 1);
      return c;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      foreach (rem[i]) rem[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 depth", stack_depth, 0);
      chk("R1 irq", irq_state, 0);
      chk("R1 irq_o", irq_o, 0);
      chk("R1 strobes", {eng_start, eng_grant, eng_abort}, 0);

      // R2: lowest pending job wins after the running one
      wr(9, 1, 0, 1, 0);
      wr(5, 1, 0, 1, 0);
      wr(2, 1, 0, 1, 0);
      idle(40);
      chk("R2 order", seq_code(), ((64'd10 << 12) | (64'd3 << 6) | 64'd6));
      // R7 finish flags and enable self-clear
      chk("R7 flags", irq_state, (32'd1 << 9) | (32'd1 << 5) | (32'd1 << 2));
      chk("R7 idle", busy, 0);
      // R8 write-one-to-clear
      clr_irq(32'd1 << 2);
      chk("R8 partial", irq_state, (32'd1 << 9) | (32'd1 << 5));
      chk("R8 irq_o kept", irq_o, 1);
      clr_irq((32'd1 << 9) | (32'd1 << 5));
      chk("R8 irq_o low", irq_o, 0);

      // R3 suspend, R4 LIFO resume
      starts.delete();
      wr(4, 1, 0, 1, 0); idle(2);
      wr(4, 0, 0, 1, 0); idle(3);
      chk("R3 idle after suspend", busy, 0);
      chk("R3 depth", stack_depth, 1);
      chk("R3 no finish", irq_state, 0);
      wr(7, 1, 0, 1, 0); idle(2);
      wr(7, 0, 0, 1, 0); idle(3);
      chk("R3 depth two", stack_depth, 2);
      wr(4, 1, 0, 1, 0); idle(5);
      chk("R4 top disabled waits", busy, 0);
      wr(7, 1, 0, 1, 0); idle(30);
      chk("R4 lifo order", seq_code(), (64'd5 << 18) | (64'd8 << 12) | (64'd8 << 6) | 64'd5);
      chk("R4 stack empty", stack_depth, 0);
      chk("R7 both done", irq_state, (32'd1 << 4) | (32'd1 << 7));
      clr_irq('1);

      // R5 cancel with a non-empty stack
      wr(10, 1, 0, 1, 0); idle(2);
      wr(10, 0, 0, 1, 0); idle(3);
      wr(11, 1, 0, 1, 0); idle(2);
      chk("R5 setup busy", busy, 1);
      wr(0, 0, 1, 0, 0);
      chk("R5 abort pulse", eng_abort, 1);
      cycle();
      chk("R5 idle", busy, 0);
      chk("R5 flushed", stack_depth, 0);
      chk("R5 abort single", eng_abort, 0);
      idle(10);
      chk("R5 no restart", busy, 0);
      chk("R5 no finish", irq_state, 0);

      // R6 hardware-triggered job
      wr(3, 1, 0, 1, 1); idle(5);
      chk("R6 waits for start", busy, 0);
      hw_start[3] = 1; cycle(); hw_start[3] = 0;
      idle(2);
      chk("R6 started", busy, 1);
      chk("R6 job", run_job, 3);
      idle(4);
      chk("R6 no grant without req", eng_grant, 0);
      for (int k = 0; k < LAT; k++) begin
         hw_req[3] = 1; cycle(); hw_req[3] = 0; cycle();
      end
      idle(3);
      chk("R6 finished", busy, 0);
      chk("R7 hw flag", irq_state, 32'd1 << 3);
      clr_irq('1);
      // R5 cancel of a hardware job
      wr(12, 1, 0, 0, 1);
      hw_start[12] = 1; cycle(); hw_start[12] = 0;
      idle(2);
      chk("R5 hw running", busy, 1);
      wr(0, 0, 1, 0, 0); idle(3);
      chk("R5 hw cancelled", busy, 0);
      hw_start[12] = 1; cycle(); hw_start[12] = 0;
      idle(3);
      chk("R5 hw enable cleared", busy, 0);

      // R7 interrupt masking
      wr(20, 1, 0, 0, 0); idle(14);
      chk("R7 masked done", busy, 0);
      chk("R7 masked flag", irq_state, 0);
      chk("R7 masked irq_o", irq_o, 0);

      // R9 every job suspended at once
      for (int j = 0; j < N; j++) begin
         wr(j, 1, 0, 0, 0); idle(2);
         wr(j, 0, 0, 0, 0); idle(3);
      end
      chk("R9 full stack", stack_depth, N);
      wr(0, 0, 1, 0, 0); idle(2);
      chk("R9 flushed", stack_depth, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule